// File: doc/BRIEF.md
# Pixel Array Readout Sequencer

This block produces the row and pixel control signals for a column-parallel, current-mode pixel array of 64 rows. Each pixel stores two samples in two memory cells, called A and B. The block runs from one main clock. Two clock-enable dividers, one dividing by ten and one by six, step the row timing. A row slot therefore lasts 30 main-clock cycles, which is the least common multiple of the two ratios. A frame lasts 64 slots, or 1920 cycles, and each frame starts directly after the previous one.

In every slot one row is sampled and the previous row is read out. The memory cell that is written changes every frame. The order in which the two stored cells are read also changes every frame, so that the column-end subtraction always takes the current sample minus the older one.

Four recirculating pattern rings decide where the windows fall inside a slot: the write strobe, the first read window, the second read window and the data-valid flag. A three-wire serial port loads new patterns into the rings. A loaded set of patterns becomes active only at the start of the next frame.

Top module: `readout_sequencer`

## Requirements
- R1: A frame has 64 row slots of 30 cycles each. `row_sample_sel` is one-hot and moves from row r to row r+1 every 30 cycles, and from row 63 back to row 0 with no idle slot. The time between frame starts is exactly 1920 cycles.
- R2: `frame_parity` is 0 (even) in the first frame after reset. It toggles in the same cycle in which `row_sample_sel` returns to row 0.
- R3: During the write window, `sample_sel` is 2'b01 (cell A) in an even frame and 2'b10 (cell B) in an odd frame. Outside the write window it is 2'b00.
- R4: For the row being read, the first read window selects the cell written in that row's frame and the second window selects the other cell. A row sampled in an even frame is therefore read A then B (`read_sel` 01 then 10), and a row sampled in an odd frame is read B then A. Row 63, read in slot 0 of the next frame, keeps the order of its own frame. Where both windows are set, the first window wins. `read_sel` is 00 outside the windows.
- R5: `row_read_sel` is the row sampled in the previous slot. It is all zero during the first slot after reset.
- R6: `data_valid` follows the valid pattern, and only while a row is being read.
- R7: After reset the patterns, by phase within the slot (0 to 29), are: write at phases 1 to 11, first read at 3 to 14, second read at 16 to 28, and valid at 9 to 14 and 24 to 28.
- R8: Each rising edge of `cfg_sclk` shifts `cfg_sdata` into a 120-bit image. Image bit 30*k+p holds phase p of pattern k, where k is 0 for write, 1 for first read, 2 for second read and 3 for valid. The last bit shifted in lands at bit 0, so a sender starts with bit 119.
- R9: A rising edge of `cfg_load` makes the image active from the first cycle of the next frame. Shifting the image without a load has no effect on any output.
- R10: All outputs are registered. While reset is high, and in the first cycle after it, every output is zero. From the first clock edge after reset is released, the outputs show phase 0 of row 0. Reset also restores the default patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sclk | input | 1 | Serial configuration shift clock (sampled, rising edge active) |
| cfg_sdata | input | 1 | Serial configuration data |
| cfg_load | input | 1 | Rising edge arms the image for the next frame |
| row_sample_sel | output | 64 | One-hot row currently sampled |
| row_read_sel | output | 64 | One-hot row currently read out (zero if none) |
| sample_sel | output | 2 | Memory cell written: 01 cell A, 10 cell B |
| read_sel | output | 2 | Memory cell driven to the column: 01 cell A, 10 cell B |
| frame_parity | output | 1 | 0 for even frames, 1 for odd frames |
| data_valid | output | 1 | Analog output valid, usable as a conversion clock |

## Verification
The assertions check several properties on every clock. The write cell always matches the frame parity. At most one read cell is selected at a time. The read row is always the row just before the sample row, and the valid flag is never high without a read row. The parity changes only when sampling returns to row 0, and it does so exactly every 1920 cycles. Only the bench scenarios can show that the window phases and read order are correct inside each slot, including at the frame seam, and they also check the serial bit order. They further check that a loaded image waits for the frame boundary, that shifting without a load leaves the outputs unchanged, and that a second reset restores the defaults.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

    localparam int NUM_PAT = 4;

    typedef enum logic [1:0] {
        PAT_WR        = 2'd0,
        PAT_RD_FIRST  = 2'd1,
        PAT_RD_SECOND = 2'd2,
        PAT_VALID     = 2'd3
    } pat_id_e;

    typedef struct packed {
        logic wr;
        logic rd_first;
        logic rd_second;
        logic valid;
    } pat_tap_t;

    localparam logic [1:0] CELL_NONE = 2'b00;
    localparam logic [1:0] CELL_A    = 2'b01;
    localparam logic [1:0] CELL_B    = 2'b10;

    function automatic int gcd_i(input int a, input int b);
        int x;
        int y;
        int t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    function automatic int lcm_i(input int a, input int b);
        return (a / gcd_i(a, b)) * b;
    endfunction

    // Default window for pattern id at phase ph of a slot of len cycles
    function automatic logic default_bit(input int id, input int ph, input int len);
        case (id)
            0:       return (ph >= 1) && (ph < (len * 2) / 5);
            1:       return (ph >= len / 10) && (ph < len / 2);
            2:       return (ph > len / 2) && (ph < len - 1);
            default: return ((ph >= (len * 3) / 10) && (ph < len / 2)) ||
                            ((ph >= (len * 4) / 5) && (ph < len - 1));
        endcase
    endfunction

    function automatic logic [1:0] cell_of(input logic parity);
        return parity ? CELL_B : CELL_A;
    endfunction

endpackage

// File: rtl/seq_cfg_port.sv
module seq_cfg_port #(
    parameter int IMG_W = 120
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_sclk,
    input  logic             cfg_sdata,
    input  logic             cfg_load,
    input  logic             frame_wrap,
    output logic [IMG_W-1:0] image,
    output logic             image_take
);
    logic [1:0]       sclk_s;
    logic [1:0]       data_s;
    logic [1:0]       load_s;
    logic             sclk_d;
    logic             load_d;
    logic             pending;
    logic [IMG_W-1:0] shreg;
    logic             shift_edge;
    logic             load_edge;

    assign shift_edge = sclk_s[1] && !sclk_d;
    assign load_edge  = load_s[1] && !load_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_s  <= '0;
            data_s  <= '0;
            load_s  <= '0;
            sclk_d  <= 1'b0;
            load_d  <= 1'b0;
            pending <= 1'b0;
            shreg   <= '0;
        end else begin
            sclk_s <= {sclk_s[0], cfg_sclk};
            data_s <= {data_s[0], cfg_sdata};
            load_s <= {load_s[0], cfg_load};
            sclk_d <= sclk_s[1];
            load_d <= load_s[1];
            if (shift_edge)
                shreg <= {shreg[IMG_W-2:0], data_s[1]};
            if (frame_wrap)
                pending <= 1'b0;
            if (load_edge)
                pending <= 1'b1;
        end
    end

    assign image      = shreg;
    assign image_take = frame_wrap && pending;

    // R8
    shift_only_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_edge |=> $stable(shreg));

endmodule

// File: rtl/seq_pattern_ring.sv
module seq_pattern_ring #(
    parameter int LEN = 30,
    parameter int ID  = 0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_en,
    input  logic [LEN-1:0] load_val,
    output logic           tap
);
    function automatic logic [LEN-1:0] build_default();
        logic [LEN-1:0] v;
        for (int p = 0; p < LEN; p++)
            v[p] = rdseq_pkg::default_bit(ID, p, LEN);
        return v;
    endfunction

    localparam logic [LEN-1:0] RING_INIT = build_default();

    logic [LEN-1:0] ring;

    always_ff @(posedge clk) begin
        if (rst)
            ring <= RING_INIT;
        else if (load_en)
            ring <= load_val;
        else
            ring <= {ring[0], ring[LEN-1:1]};
    end

    assign tap = ring[0];

endmodule

// File: rtl/seq_row_timer.sv
module seq_row_timer #(
    parameter int ROWS  = 64,
    parameter int DIV_A = 10,
    parameter int DIV_B = 6
) (
    input  logic            clk,
    input  logic            rst,
    output logic [ROWS-1:0] samp_row,
    output logic [ROWS-1:0] read_row,
    output logic            samp_par,
    output logic            read_par,
    output logic            read_act,
    output logic            frame_wrap
);
    localparam int CA_W = (DIV_A > 1) ? $clog2(DIV_A) : 1;
    localparam int CB_W = (DIV_B > 1) ? $clog2(DIV_B) : 1;

    logic [CA_W-1:0] ca;
    logic [CB_W-1:0] cb;
    logic            tick_a;
    logic            tick_b;
    logic            slot_end;

    assign tick_a     = (ca == CA_W'(DIV_A - 1));
    assign tick_b     = (cb == CB_W'(DIV_B - 1));
    assign slot_end   = tick_a && tick_b;
    assign frame_wrap = slot_end && samp_row[ROWS-1];
    assign read_act   = |read_row;

    always_ff @(posedge clk) begin
        if (rst) begin
            ca       <= '0;
            cb       <= '0;
            samp_row <= ROWS'(1);
            read_row <= '0;
            samp_par <= 1'b0;
            read_par <= 1'b0;
        end else begin
            ca <= tick_a ? '0 : ca + 1'b1;
            cb <= tick_b ? '0 : cb + 1'b1;
            if (slot_end) begin
                samp_row <= {samp_row[ROWS-2:0], samp_row[ROWS-1]};
                read_row <= samp_row;
                read_par <= samp_par;
                if (samp_row[ROWS-1])
                    samp_par <= ~samp_par;
            end
        end
    end

    // R1
    one_row_sampled_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot(samp_row));

endmodule

// File: rtl/readout_sequencer.sv
module readout_sequencer #(
    parameter int NUM_ROWS = 64,
    parameter int DIV_A    = 10,
    parameter int DIV_B    = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_sclk,
    input  logic                cfg_sdata,
    input  logic                cfg_load,
    output logic [NUM_ROWS-1:0] row_sample_sel,
    output logic [NUM_ROWS-1:0] row_read_sel,
    output logic [1:0]          sample_sel,
    output logic [1:0]          read_sel,
    output logic                frame_parity,
    output logic                data_valid
);
    import rdseq_pkg::*;

    localparam int ROW_CYC   = lcm_i(DIV_A, DIV_B);
    localparam int FRAME_CYC = NUM_ROWS * ROW_CYC;
    localparam int IMG_W     = NUM_PAT * ROW_CYC;
    localparam int FL_W      = $clog2(FRAME_CYC + 1);

    logic [NUM_ROWS-1:0] samp_row;
    logic [NUM_ROWS-1:0] read_row;
    logic                samp_par;
    logic                read_par;
    logic                read_act;
    logic                frame_wrap;
    logic [IMG_W-1:0]    image;
    logic                image_take;
    logic [NUM_PAT-1:0]  taps;
    pat_tap_t            tp;
    logic [1:0]          ssel_c;
    logic [1:0]          rsel_c;

    seq_row_timer #(.ROWS(NUM_ROWS), .DIV_A(DIV_A), .DIV_B(DIV_B)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .samp_row   (samp_row),
        .read_row   (read_row),
        .samp_par   (samp_par),
        .read_par   (read_par),
        .read_act   (read_act),
        .frame_wrap (frame_wrap)
    );

    seq_cfg_port #(.IMG_W(IMG_W)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .cfg_sclk   (cfg_sclk),
        .cfg_sdata  (cfg_sdata),
        .cfg_load   (cfg_load),
        .frame_wrap (frame_wrap),
        .image      (image),
        .image_take (image_take)
    );

    for (genvar g = 0; g < NUM_PAT; g++) begin : g_ring
        seq_pattern_ring #(.LEN(ROW_CYC), .ID(g)) u_ring (
            .clk      (clk),
            .rst      (rst),
            .load_en  (image_take),
            .load_val (image[g*ROW_CYC +: ROW_CYC]),
            .tap      (taps[g])
        );
    end

    assign tp.wr        = taps[PAT_WR];
    assign tp.rd_first  = taps[PAT_RD_FIRST];
    assign tp.rd_second = taps[PAT_RD_SECOND];
    assign tp.valid     = taps[PAT_VALID];

    always_comb begin
        ssel_c = tp.wr ? cell_of(samp_par) : CELL_NONE;
        if (!read_act)
            rsel_c = CELL_NONE;
        else if (tp.rd_first)
            rsel_c = cell_of(read_par);
        else if (tp.rd_second)
            rsel_c = cell_of(!read_par);
        else
            rsel_c = CELL_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_sample_sel <= '0;
            row_read_sel   <= '0;
            sample_sel     <= CELL_NONE;
            read_sel       <= CELL_NONE;
            frame_parity   <= 1'b0;
            data_valid     <= 1'b0;
        end else begin
            row_sample_sel <= samp_row;
            row_read_sel   <= read_row;
            sample_sel     <= ssel_c;
            read_sel       <= rsel_c;
            frame_parity   <= samp_par;
            data_valid     <= tp.valid && read_act;
        end
    end

    // Checker state: cycles between observed parity changes
    logic [FL_W-1:0] fl_cnt;
    logic            fl_seen;
    logic            par_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_cnt  <= '0;
            fl_seen <= 1'b0;
            par_q   <= 1'b0;
        end else begin
            par_q <= frame_parity;
            if (frame_parity != par_q) begin
                fl_cnt  <= '0;
                fl_seen <= 1'b1;
            end else if (fl_cnt != '1) begin
                fl_cnt <= fl_cnt + 1'b1;
            end
        end
    end

    // R1
    frame_length_chk: assert property (@(posedge clk) disable iff (rst)
        (fl_seen && (frame_parity != par_q)) |-> (fl_cnt == FL_W'(FRAME_CYC - 1)));

    // R2
    parity_at_row0_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(frame_parity) |-> (row_sample_sel[0] && $past(row_sample_sel[NUM_ROWS-1])));

    // R3
    write_cell_parity_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_sel != CELL_NONE) |-> (sample_sel == (frame_parity ? CELL_B : CELL_A)));

    // R4
    one_cell_read_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(read_sel));

    // R5
    read_trails_sample_chk: assert property (@(posedge clk) disable iff (rst)
        (row_read_sel != '0) |->
        ({row_read_sel[NUM_ROWS-2:0], row_read_sel[NUM_ROWS-1]} == row_sample_sel));

    // R6
    valid_needs_row_chk: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> (row_read_sel != '0));

endmodule

// File: tb/readout_sequencer_test.sv
module readout_sequencer_test;
    localparam int ROWS  = 64;
    localparam int SLOT  = 30;
    localparam int FRAME = ROWS * SLOT;
    localparam int NP    = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_sclk = 1'b0;
    logic cfg_sdata = 1'b0;
    logic cfg_load = 1'b0;
    logic [ROWS-1:0] row_sample_sel;
    logic [ROWS-1:0] row_read_sel;
    logic [1:0] sample_sel;
    logic [1:0] read_sel;
    logic frame_parity;
    logic data_valid;

    readout_sequencer uut (
        .clk(clk), .rst(rst), .cfg_sclk(cfg_sclk), .cfg_sdata(cfg_sdata),
        .cfg_load(cfg_load), .row_sample_sel(row_sample_sel),
        .row_read_sel(row_read_sel), .sample_sel(sample_sel), .read_sel(read_sel),
        .frame_parity(frame_parity), .data_valid(data_valid)
    );

    always #10 clk = ~clk;

    int k = 0;
    logic rst_q = 1'b1;
    int cmp_n = 0;
    int bad_n = 0;
    bit done = 0;
    bit [SLOT-1:0] pat_old [NP];
    bit [SLOT-1:0] pat_new [NP];
    int sw_frame = 32'h3fff_ffff;

    always @(posedge clk) begin
        rst_q <= rst;
        if (rst) k <= 0;
        else k <= k + 1;
    end

    task automatic check(input string req, input string name, input string ctx,
                         input logic [63:0] act, input logic [63:0] exp);
        cmp_n++;
        if (act !== exp) begin
            bad_n++;
            if (bad_n <= 30)
                $display("FAIL %s %s (%s) cycle %0d: actual %0h expected %0h",
                         req, name, ctx, k, act, exp);
        end
    endtask

    // Reference model: outputs after k edges show the state of cycle k-1
    always @(negedge clk) begin
        int n, ph, slot, rrow, rpar, spar, srow;
        bit use_new, ract;
        bit [SLOT-1:0] cur [NP];
        logic [ROWS-1:0] e_rs, e_rr;
        logic [1:0] e_ss, e_rd;
        logic e_fp, e_dv;
        string ctx;
        if (!done) begin
            if (rst_q || k == 0) begin
                check("R10", "row_sample_sel", "reset", row_sample_sel, 0);
                check("R10", "row_read_sel", "reset", row_read_sel, 0);
                check("R10", "cells", "reset", {sample_sel, read_sel}, 0);
                check("R10", "flags", "reset", {frame_parity, data_valid}, 0);
            end else begin
                n = k - 1;
                ph = n % SLOT;
                slot = n / SLOT;
                use_new = (n / FRAME) >= sw_frame;
                ctx = use_new ? "R8 R9 loaded" : "R7 default";
                for (int i = 0; i < NP; i++) cur[i] = use_new ? pat_new[i] : pat_old[i];
                srow = slot % ROWS;
                spar = (slot / ROWS) % 2;
                ract = slot >= 1;
                rrow = ract ? (slot - 1) % ROWS : 0;
                rpar = ract ? ((slot - 1) / ROWS) % 2 : 0;
                e_rs = '0; e_rs[srow] = 1'b1;
                e_rr = '0; if (ract) e_rr[rrow] = 1'b1;
                e_fp = spar[0];
                e_ss = cur[0][ph] ? (spar ? 2'b10 : 2'b01) : 2'b00;
                e_rd = 2'b00;
                if (ract && cur[1][ph]) e_rd = rpar ? 2'b10 : 2'b01;
                else if (ract && cur[2][ph]) e_rd = rpar ? 2'b01 : 2'b10;
                e_dv = ract && cur[3][ph];
                check("R1", "row_sample_sel", ctx, row_sample_sel, e_rs);
                check("R5", "row_read_sel", ctx, row_read_sel, e_rr);
                check("R2", "frame_parity", ctx, frame_parity, e_fp);
                check("R3", "sample_sel", ctx, sample_sel, e_ss);
                check("R4", "read_sel", ctx, read_sel, e_rd);
                check("R6", "data_valid", ctx, data_valid, e_dv);
            end
        end
    end

    task automatic set_defaults();
        for (int p = 0; p < SLOT; p++) begin
            pat_old[0][p] = (p >= 1 && p <= 11);
            pat_old[1][p] = (p >= 3 && p <= 14);
            pat_old[2][p] = (p >= 16 && p <= 28);
            pat_old[3][p] = (p >= 9 && p <= 14) || (p >= 24 && p <= 28);
        end
        sw_frame = 32'h3fff_ffff;
    endtask

    // R8: send image bits 119 down to 0
    task automatic send_image(input bit all_ones);
        for (int i = NP * SLOT - 1; i >= 0; i--) begin
            cfg_sdata = all_ones ? 1'b1 : pat_new[i / SLOT][i % SLOT];
            repeat (2) @(negedge clk);
            cfg_sclk = 1'b1;
            repeat (2) @(negedge clk);
            cfg_sclk = 1'b0;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmp_n, bad_n);
        $finish;
    endtask

    initial begin
        set_defaults();
        for (int p = 0; p < SLOT; p++) begin
            pat_new[0][p] = (p <= 4);
            pat_new[1][p] = (p >= 5 && p <= 12);
            pat_new[2][p] = (p >= 10 && p <= 20) || (p == 29);
            pat_new[3][p] = (p == 0) || (p == 7) || (p == 29);
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (300) @(negedge clk);
        // R9: shift without load must leave outputs on default patterns
        send_image(1'b1);
        while (k < FRAME + 100) @(negedge clk);
        send_image(1'b0);
        while ((k % FRAME) < 200 || (k % FRAME) > FRAME - 200) @(negedge clk);
        cfg_load = 1'b1;
        sw_frame = k / FRAME + 1;
        repeat (6) @(negedge clk);
        cfg_load = 1'b0;
        while (k < (sw_frame + 2) * FRAME + 50) @(negedge clk);
        // R10: second reset restores defaults
        rst = 1'b1;
        repeat (3) @(negedge clk);
        set_defaults();
        rst = 1'b0;
        repeat (FRAME + 200) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (60000) @(posedge clk);
        cmp_n++;
        bad_n++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

endmodule